// File: doc/BRIEF.md
# LPC Memory-Cycle Target Decoder

This block is the target side of a Low Pin Count bus interface. It watches the active-low framing strobe and the 4-bit multiplexed address/data lines on every rising clock edge. It recognises memory read and memory write cycles and collects the 32-bit address. If the address falls inside the device window and carries the expected identity bits, it performs the access. It then answers the host with turnaround, sync and read-data nibbles in a fixed order.

One address bit steers each access to one of two stores. The first is a small byte-wide flash image array. The second is a separate byte-wide register file. The flash image holds `2**FLASH_AW` bytes and the register file holds `2**REG_AW` bytes. Any cycle the block does not accept is dropped silently: the lines stay undriven and the target waits for the next start.

The host can cut a cycle short at any point by pulling the strobe low again. If it presents the all-ones nibble while framed, the target goes back to idle. If it presents the start nibble instead, a new cycle begins at once.

Top module: `lpcmt_target`

## Requirements
- R1: After reset the nibble output enable is low and every byte of both stores reads as 0x00.
- R2: A clock with the strobe low and the lines at 0000b begins a cycle; framed clocks repeat the start and the last one counts; a framed nibble other than 0000b leaves the target idle and gets no response.
- R3: The nibble after the start picks the cycle kind: 010xb is a memory read, 011xb is a memory write, and any other value makes the target ignore the rest of the cycle.
- R4: The address arrives over the next eight clocks, most significant nibble first, forming A31..A0.
- R5: A cycle is accepted only if A31..A26 and A21..A19 are all ones; any other address is ignored.
- R6: A25..A23 must equal the 3-bit `id_strap` input; on a mismatch the cycle is ignored.
- R7: A22 = 1 sends the access to the flash image at offset A[FLASH_AW-1:0]. A22 = 0 sends it to the register file at offset A[REG_AW-1:0]. The two stores are independent.
- R8: A write carries two data nibbles after the address, low nibble first. The byte is stored on the clock that samples the high nibble.
- R9: After the last address nibble of a read, or the last data nibble of a write, the target stays undriven for two clocks. It then drives SYNC = 0000b for one clock. A read follows with the data byte low nibble first. The target then stays undriven for two clocks and returns to idle.
- R10: An ignored cycle never drives the lines; the target returns to idle right after the address and disregards later nibbles until the next framed start.
- R11: The strobe going low during a cycle ends it at once and the output enable drops on that clock; 1111b returns to idle, 0000b starts a new cycle.
- R12: An abort after the high data nibble of a write leaves the stored byte in place; an abort before that clock leaves the store unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low cycle framing strobe |
| nib_in | input | 4 | Nibble presented by the host |
| id_strap | input | 3 | Hardware identity strap compared with A25..A23 |
| nib_out | output | 4 | Nibble driven by the target |
| nib_oe | output | 1 | High while the target drives the nibble lines |

## Verification
Every response is tied to the clock that samples the last address nibble of a read, or the high data nibble of a write. The output enable stays low for the two clocks after that edge and rises with SYNC on the third. For a read, the low and high data nibbles follow on the fourth and fifth clocks. An abort or a restart shows on the clock right after the framed nibble is sampled. The bench's reference model builds, for each cycle, the expected enable and nibble for every clock in that order. It drives one nibble per clock at the falling edge and compares the outputs at the next falling edge, after the rising edge that consumed the nibble. Stores are checked only through later read cycles, so dropped writes and aborted writes are judged at the ports.

// File: rtl/lpcmt_pkg.sv
package lpcmt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_TYPE, ST_ADDR, ST_WD0, ST_WD1, ST_TAR1, ST_TAR2,
    ST_SYNC, ST_RD0, ST_RD1, ST_RTA1, ST_RTA2
  } lpc_state_e;

  localparam int          ADDR_NIBS = 8;
  localparam int          ID_W      = 3;
  localparam logic [3:0]  NIB_START = 4'h0;
  localparam logic [3:0]  NIB_SYNC  = 4'h0;

  // Upper address slice A31..A19: window bits all ones, identity field equal to strap.
  function automatic logic addr_match(input logic [31:19] hi, input logic [ID_W-1:0] strap);
    logic window;
    window = (&hi[31:26]) && (&hi[21:19]);
    return window && (hi[25:23] == strap) && (hi[22] == 1'b1 || hi[22] == 1'b0);
  endfunction

  // Upper two bits of the cycle-kind nibble select memory cycles (01xx).
  function automatic logic mem_kind(input logic [1:0] top2);
    return top2 == 2'b01;
  endfunction

endpackage

// File: rtl/lpcmt_frame_fsm.sv
module lpcmt_frame_fsm
  import lpcmt_pkg::*;
#(
  parameter int FLASH_AW = 6,
  parameter int REG_AW   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_n,
  input  logic [3:0]          nib_in,
  input  logic [ID_W-1:0]     id_strap,
  output lpc_state_e          state,
  output logic                is_write,
  output logic                addr_done,
  output logic                addr_hit,
  output logic                wr_commit,
  output logic [7:0]          wr_data,
  output logic                sel_flash,
  output logic [FLASH_AW-1:0] flash_idx,
  output logic [REG_AW-1:0]   reg_idx
);

  localparam int CNT_W = $clog2(ADDR_NIBS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIBS - 1);

  lpc_state_e       state_q, state_d;
  logic [27:0]      addr_q;
  logic [31:0]      addr_full;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       wlo_q;
  logic             wr_q;

  assign addr_full = {addr_q, nib_in};
  assign addr_hit  = addr_match(addr_full[31:19], id_strap);

  always_comb begin
    state_d   = state_q;
    addr_done = 1'b0;
    wr_commit = 1'b0;
    if (!frame_n) begin
      state_d = (nib_in == NIB_START) ? ST_TYPE : ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_IDLE;
        ST_TYPE: state_d = mem_kind(nib_in[3:2]) ? ST_ADDR : ST_IDLE;
        ST_ADDR: begin
          if (cnt_q == CNT_LAST) begin
            addr_done = 1'b1;
            if (!addr_hit)  state_d = ST_IDLE;
            else if (wr_q)  state_d = ST_WD0;
            else            state_d = ST_TAR1;
          end
        end
        ST_WD0:  state_d = ST_WD1;
        ST_WD1: begin
          wr_commit = 1'b1;
          state_d   = ST_TAR1;
        end
        ST_TAR1: state_d = ST_TAR2;
        ST_TAR2: state_d = ST_SYNC;
        ST_SYNC: state_d = wr_q ? ST_RTA1 : ST_RD0;
        ST_RD0:  state_d = ST_RD1;
        ST_RD1:  state_d = ST_RTA1;
        ST_RTA1: state_d = ST_RTA2;
        ST_RTA2: state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      wlo_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (frame_n && state_q == ST_TYPE) begin
        wr_q  <= nib_in[1];
        cnt_q <= '0;
      end
      if (frame_n && state_q == ST_ADDR) begin
        addr_q <= addr_full[27:0];
        cnt_q  <= cnt_q + 1'b1;
      end
      if (frame_n && state_q == ST_WD0) wlo_q <= nib_in;
    end
  end

  assign state     = state_q;
  assign is_write  = wr_q;
  assign wr_data   = {nib_in, wlo_q};
  assign sel_flash = addr_q[22];
  assign flash_idx = addr_q[FLASH_AW-1:0];
  assign reg_idx   = addr_q[REG_AW-1:0];

endmodule

// File: rtl/lpcmt_store.sv
module lpcmt_store #(
  parameter int FLASH_AW = 6,
  parameter int REG_AW   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_latch,
  input  logic                sel_flash,
  input  logic [FLASH_AW-1:0] flash_idx,
  input  logic [REG_AW-1:0]   reg_idx,
  input  logic [7:0]          wr_data,
  output logic [7:0]          rd_byte
);

  localparam int FLASH_N = 1 << FLASH_AW;
  localparam int REG_N   = 1 << REG_AW;

  logic [7:0] flash_mem [FLASH_N];
  logic [7:0] reg_mem   [REG_N];

  generate
    for (genvar i = 0; i < FLASH_N; i++) begin : g_flash
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                           flash_mem[i] <= '0;
        else if (wr_en && sel_flash && flash_idx == FLASH_AW'(i)) flash_mem[i] <= wr_data;
      end
    end
    for (genvar j = 0; j < REG_N; j++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          reg_mem[j] <= '0;
        else if (wr_en && !sel_flash && reg_idx == REG_AW'(j)) reg_mem[j] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_byte <= '0;
    else if (rd_latch) rd_byte <= sel_flash ? flash_mem[flash_idx] : reg_mem[reg_idx];
  end

endmodule

// File: rtl/lpcmt_drive.sv
module lpcmt_drive
  import lpcmt_pkg::*;
(
  input  lpc_state_e state,
  input  logic [7:0] rd_byte,
  output logic [3:0] nib_out,
  output logic       nib_oe
);

  always_comb begin
    nib_oe  = 1'b0;
    nib_out = 4'h0;
    unique case (state)
      ST_SYNC: begin nib_oe = 1'b1; nib_out = NIB_SYNC;     end
      ST_RD0:  begin nib_oe = 1'b1; nib_out = rd_byte[3:0]; end
      ST_RD1:  begin nib_oe = 1'b1; nib_out = rd_byte[7:4]; end
      default: begin nib_oe = 1'b0; nib_out = 4'h0;         end
    endcase
  end

endmodule

// File: rtl/lpcmt_target.sv
module lpcmt_target
  import lpcmt_pkg::*;
#(
  parameter int FLASH_AW = 6,
  parameter int REG_AW   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic [3:0]  nib_in,
  input  logic [2:0]  id_strap,
  output logic [3:0]  nib_out,
  output logic        nib_oe
);

  lpc_state_e          state;
  logic                is_write;
  logic                addr_done;
  logic                addr_hit;
  logic                wr_commit;
  logic [7:0]          wr_data;
  logic                sel_flash;
  logic [FLASH_AW-1:0] flash_idx;
  logic [REG_AW-1:0]   reg_idx;
  logic [7:0]          rd_byte;
  logic                rd_latch;

  assign rd_latch = frame_n && (state == ST_TAR2) && !is_write;

  lpcmt_frame_fsm #(.FLASH_AW(FLASH_AW), .REG_AW(REG_AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .nib_in(nib_in), .id_strap(id_strap),
    .state(state), .is_write(is_write), .addr_done(addr_done), .addr_hit(addr_hit),
    .wr_commit(wr_commit), .wr_data(wr_data), .sel_flash(sel_flash),
    .flash_idx(flash_idx), .reg_idx(reg_idx)
  );

  lpcmt_store #(.FLASH_AW(FLASH_AW), .REG_AW(REG_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_commit), .rd_latch(rd_latch),
    .sel_flash(sel_flash), .flash_idx(flash_idx), .reg_idx(reg_idx),
    .wr_data(wr_data), .rd_byte(rd_byte)
  );

  lpcmt_drive u_drive (
    .state(state), .rd_byte(rd_byte), .nib_out(nib_out), .nib_oe(nib_oe)
  );

endmodule

// File: rtl/lpcmt_checker.sv
module lpcmt_checker
  import lpcmt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic [3:0] nib_in,
  input lpc_state_e state,
  input logic       addr_done,
  input logic       addr_hit,
  input logic       wr_commit,
  input logic [3:0] nib_out,
  input logic       nib_oe
);

  // R2: a framed start nibble opens the cycle-kind phase
  a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && nib_in == 4'h0) |=> state == ST_TYPE);

  // R3: a non-memory kind nibble drops the cycle
  a_r3_bad_kind_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && state == ST_TYPE && nib_in[3:2] != 2'b01) |=> state == ST_IDLE);

  // R10: a missed address returns to idle without driving
  a_r10_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !addr_hit) |=> (state == ST_IDLE && !nib_oe));

  // R9: the first driven nibble of any response is SYNC 0000b
  a_r9_sync_leads: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_oe && !$past(nib_oe)) |-> nib_out == 4'h0);

  // R11: framed all-ones nibble aborts to idle with the lines released
  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && nib_in == 4'hF) |=> (state == ST_IDLE && !nib_oe));

  // R12: a stored write is followed by the first turnaround clock
  a_r12_commit_then_tar: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> state == ST_TAR1);

endmodule

bind lpcmt_target lpcmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .nib_in(nib_in), .state(state),
  .addr_done(addr_done), .addr_hit(addr_hit), .wr_commit(wr_commit),
  .nib_out(nib_out), .nib_oe(nib_oe)
);

// File: tb/lpcmt_target_test.sv
module lpcmt_target_test;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_n;
  logic [3:0] nib_in;
  logic [2:0] id_strap;
  logic [3:0] nib_out;
  logic       nib_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  lpcmt_target uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .nib_in(nib_in),
    .id_strap(id_strap), .nib_out(nib_out), .nib_oe(nib_oe)
  );

  typedef struct {
    bit         fr;
    logic [3:0] nib;
    bit         oe;
    logic [3:0] val;
    bit         commit;
  } ent_t;

  // behavioural model of the two stores
  logic [7:0] flash_m [64];
  logic [7:0] reg_m   [8];
  bit         pend_flash;
  int         pend_idx;
  logic [7:0] pend_data;

  ent_t cyc[$];

  function automatic bit model_hit(input logic [31:0] a);
    return (a >> 26) == 32'h3F && ((a >> 19) & 32'h7) == 32'h7
           && ((a >> 23) & 32'h7) == 32'(id_strap);
  endfunction

  function automatic ent_t mk(input bit fr, input logic [3:0] n, input bit oe,
                              input logic [3:0] v, input bit c);
    ent_t e;
    e.fr = fr; e.nib = n; e.oe = oe; e.val = v; e.commit = c;
    return e;
  endfunction

  // Build the per-clock expectation of one cycle into cyc.
  task automatic build(input logic [3:0] startn, input logic [3:0] kind,
                       input logic [31:0] a, input logic [7:0] d);
    bit ok;
    bit wr;
    logic [7:0] rd;
    cyc.delete();
    cyc.push_back(mk(1'b0, startn, 1'b0, 4'h0, 1'b0));
    ok = (startn == 4'h0) && (kind[3:2] == 2'b01);
    wr = kind[1];
    cyc.push_back(mk(1'b1, kind, 1'b0, 4'h0, 1'b0));
    for (int i = 7; i >= 0; i--) cyc.push_back(mk(1'b1, 4'((a >> (4*i)) & 32'hF), 1'b0, 4'h0, 1'b0));
    if (!(ok && model_hit(a))) begin
      if (wr) begin
        cyc.push_back(mk(1'b1, d[3:0], 1'b0, 4'h0, 1'b0));
        cyc.push_back(mk(1'b1, d[7:4], 1'b0, 4'h0, 1'b0));
      end
      cyc.push_back(mk(1'b1, 4'hF, 1'b0, 4'h0, 1'b0));
      cyc.push_back(mk(1'b1, 4'hF, 1'b0, 4'h0, 1'b0));
      cyc.push_back(mk(1'b1, 4'hF, 1'b0, 4'h0, 1'b0));
      return;
    end
    pend_flash = a[22];
    pend_idx   = a[22] ? int'(a & 32'h3F) : int'(a & 32'h7);
    pend_data  = d;
    rd = a[22] ? flash_m[a & 32'h3F] : reg_m[a & 32'h7];
    if (wr) begin
      cyc.push_back(mk(1'b1, d[3:0], 1'b0, 4'h0, 1'b0));
      cyc.push_back(mk(1'b1, d[7:4], 1'b0, 4'h0, 1'b1));
    end
    cyc.push_back(mk(1'b1, 4'hF, 1'b0, 4'h0, 1'b0));
    cyc.push_back(mk(1'b1, 4'hF, 1'b1, 4'h0, 1'b0));
    if (!wr) begin
      cyc.push_back(mk(1'b1, 4'hF, 1'b1, rd[3:0], 1'b0));
      cyc.push_back(mk(1'b1, 4'hF, 1'b1, rd[7:4], 1'b0));
    end
    cyc.push_back(mk(1'b1, 4'hF, 1'b0, 4'h0, 1'b0));
    cyc.push_back(mk(1'b1, 4'hF, 1'b0, 4'h0, 1'b0));
    cyc.push_back(mk(1'b1, 4'hF, 1'b0, 4'h0, 1'b0));
  endtask

  // One clock: drive at the falling edge, compare at the next falling edge.
  task automatic step(input ent_t e, input string tag);
    frame_n = e.fr;
    nib_in  = e.nib;
    @(negedge clk);
    if (e.commit) begin
      if (pend_flash) flash_m[pend_idx] = pend_data;
      else            reg_m[pend_idx]   = pend_data;
    end
    checks++;
    if (nib_oe !== e.oe || (e.oe && nib_out !== e.val)) begin
      fails++;
      $display("FAIL %s: oe=%b nib=%h expected oe=%b nib=%h", tag, nib_oe, nib_out, e.oe, e.val);
    end
  endtask

  // Play the first n entries of cyc (all when n < 0).
  task automatic play(input int n, input string tag);
    int lim;
    lim = (n < 0 || n > cyc.size()) ? cyc.size() : n;
    for (int i = 0; i < lim; i++) step(cyc[i], tag);
  endtask

  task automatic abort_now(input string tag);
    step(mk(1'b0, 4'hF, 1'b0, 4'h0, 1'b0), tag);
    step(mk(1'b1, 4'hF, 1'b0, 4'h0, 1'b0), tag);
  endtask

  localparam logic [31:0] FL = 32'hFEF8_0000;  // strap 101, A22 = 1
  localparam logic [31:0] RG = 32'hFEB8_0000;  // strap 101, A22 = 0

  initial begin
    for (int i = 0; i < 64; i++) flash_m[i] = 8'h00;
    for (int i = 0; i < 8; i++)  reg_m[i]   = 8'h00;
    rst_n = 1'b0; frame_n = 1'b1; nib_in = 4'hF; id_strap = 3'b101;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (nib_oe !== 1'b0) begin fails++; $display("FAIL R1 reset: oe=%b expected 0", nib_oe); end

    build(4'h0, 4'h4, FL | 32'h05, 8'h00); play(-1, "R1 flash reads zero");
    build(4'h0, 4'h4, RG | 32'h05, 8'h00); play(-1, "R1 reg reads zero");
    build(4'h0, 4'h6, FL | 32'h05, 8'h3C); play(-1, "R8 flash write");
    build(4'h0, 4'h4, FL | 32'h05, 8'h00); play(-1, "R4 R9 flash readback");
    build(4'h0, 4'h7, RG | 32'h05, 8'hA7); play(-1, "R7 reg write");
    build(4'h0, 4'h4, FL | 32'h05, 8'h00); play(-1, "R7 flash untouched");
    build(4'h0, 4'h5, RG | 32'h05, 8'h00); play(-1, "R3 R7 reg read kind 0101");
    build(4'h0, 4'h6, FL | 32'h2A, 8'h96); play(-1, "R8 second flash write");
    build(4'h0, 4'h4, FL | 32'h2A, 8'h00); play(-1, "R4 flash readback 2A");

    build(4'h0, 4'h6, 32'hFE78_0005, 8'h11); play(-1, "R6 id mismatch write");
    build(4'h0, 4'h6, 32'h7EF8_0005, 8'h22); play(-1, "R5 out of window write");
    build(4'h0, 4'h6, 32'hFEF0_0005, 8'h33); play(-1, "R5 A19 clear write");
    build(4'h0, 4'h4, FL | 32'h05, 8'h00); play(-1, "R10 flash unchanged after misses");
    build(4'h0, 4'h2, FL | 32'h05, 8'h00); play(-1, "R3 non-memory kind");
    build(4'h0, 4'hE, FL | 32'h05, 8'h00); play(-1, "R3 kind 1110");
    build(4'h3, 4'h4, FL | 32'h05, 8'h00); play(-1, "R2 bad start nibble");

    step(mk(1'b0, 4'h0, 1'b0, 4'h0, 1'b0), "R2 repeated start");
    build(4'h0, 4'h4, RG | 32'h05, 8'h00); play(-1, "R2 repeated start read");

    build(4'h0, 4'h6, FL | 32'h05, 8'hEE); play(6, "R11 abort in address");
    abort_now("R11 abort in address");
    build(4'h0, 4'h6, FL | 32'h05, 8'hEE); play(11, "R12 abort before high nibble");
    abort_now("R12 abort before high nibble");
    build(4'h0, 4'h4, FL | 32'h05, 8'h00); play(-1, "R12 store unchanged");

    build(4'h0, 4'h7, RG | 32'h03, 8'h5B); play(13, "R12 abort in turnaround");
    abort_now("R12 abort in turnaround");
    build(4'h0, 4'h4, RG | 32'h03, 8'h00); play(-1, "R12 write kept after abort");

    build(4'h0, 4'h4, FL | 32'h2A, 8'h00); play(13, "R11 abort in read data");
    abort_now("R11 abort in read data");

    build(4'h0, 4'h4, FL | 32'h05, 8'h00); play(5, "R11 restart source");
    build(4'h0, 4'h4, RG | 32'h03, 8'h00); play(-1, "R11 restart read");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule